// File: doc/BRIEF.md
# Barrel Shifter with Carry Out

This block is a purely combinational 32-bit shifter for the operand path of an integer datapath. In a single pass it applies one of five operations to an operand: shift left with zero fill, shift right with zero fill, shift right with sign fill, rotate right, or a one-place rotate right that runs through the carry flag. The first four take a distance from 0 to 31. The fifth treats the carry flag and the operand together as a 33-bit ring.

Next to the shifted word the block produces a carry-out. For the four distance-driven operations this is the final bit that left the operand. A downstream ALU can use it as the C flag for logical operations. With a zero distance, the word passes through untouched and the incoming carry is handed back unchanged. The block stores no flags and never sees distances above 31.

Top module: `barrel_shifter_cout`

## Requirements
- R1: With `kind_i` = 3'b000, `res_o` is `op_i` shifted left by `amt_i` with zeros filling the vacated low bits (0xFFFFFF00 by 4 gives 0xFFFFF000).
- R2: With `kind_i` = 3'b001, `res_o` is `op_i` shifted right by `amt_i` with zeros filling the vacated high bits (0xFFFFFF00 by 4 gives 0x0FFFFFF0).
- R3: With `kind_i` = 3'b010, `res_o` is `op_i` shifted right by `amt_i` with copies of the original bit 31 filling the vacated high bits (0xFFFFFF00 by 4 gives 0xFFFFFFF0).
- R4: With `kind_i` = 3'b011, `res_o` is `op_i` rotated right by `amt_i`, so bits leaving bit 0 re-enter at bit 31 (0x12345678 by 4 gives 0x81234567).
- R5: With `kind_i` = 3'b100, `res_o` is `{cin_i, op_i[31:1]}` and `cout_o` is `op_i[0]`.
- R6: For kinds 3'b000 to 3'b011 with `amt_i` from 1 to 31, `cout_o` is the last operand bit shifted out. That bit is `op_i[32-amt_i]` for the left shift and `op_i[amt_i-1]` for the three right operations.
- R7: For kinds 3'b000 to 3'b011 with `amt_i` = 0, `res_o` equals `op_i` and `cout_o` equals `cin_i`.
- R8: The unused codes 3'b101, 3'b110 and 3'b111 pass `op_i` unchanged to `res_o`, and `cout_o` equals `cin_i`.
- R9: With `kind_i` = 3'b100, `amt_i` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 32 | Operand to be shifted |
| kind_i | input | 3 | Operation select: 000 left, 001 right logical, 010 right arithmetic, 011 rotate, 100 rotate through carry |
| amt_i | input | 5 | Shift distance, 0 to 31 |
| cin_i | input | 1 | Current carry flag |
| res_o | output | 32 | Shifted result |
| cout_o | output | 1 | Shifter carry-out |

## Verification
The hardest behaviour to expose is the carry-out at the extreme distances. A left shift by 31 must return bit 1 as the carry, and a right shift by 31 must return bit 30. Only an operand with a single bit set in the right place shows an error in the carry select. The stimulus therefore sweeps every distance from 0 to 31 for each kind, and at each distance it uses a walking single-bit operand set to the exact position expected to leave last, together with its complement and pseudo-random words. The zero-distance and rotate-through-carry cases are run with both carry values so that a swapped carry source becomes visible.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    SK_LSL = 3'b000,
    SK_LSR = 3'b001,
    SK_ASR = 3'b010,
    SK_ROR = 3'b011,
    SK_RCX = 3'b100
  } shift_kind_e;
endpackage

// File: rtl/bsh_rotr.sv
// Logarithmic right rotator: one mux stage per distance bit.
module bsh_rotr #(
  parameter int unsigned W  = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stg [AW+1];

  assign stg[0] = data_i;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stg[s+1] = amt_i[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
  end

  assign data_o = stg[AW];
endmodule

// File: rtl/bsh_fill_mask.sv
// Marks which result bits hold operand bits (1) and which are vacated (0).
module bsh_fill_mask #(
  parameter int unsigned W  = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  output logic [W-1:0]  keep_o
);
  localparam logic [AW:0] WV = (AW+1)'(W);
  logic [AW:0] amt_x;

  assign amt_x = {1'b0, amt_i};

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [AW:0] IDX = (AW+1)'(i);
    logic keep_left;
    logic keep_right;
    assign keep_left  = (IDX >= amt_x);
    assign keep_right = ((IDX + amt_x) < WV);
    assign keep_o[i]  = left_i ? keep_left : keep_right;
  end
endmodule

// File: rtl/bsh_carry_sel.sv
// Carry-out select: the bit that left last sits at an edge of the rotated word.
module bsh_carry_sel #(
  parameter int unsigned W = 32
) (
  input  bsh_pkg::shift_kind_e kind_i,
  input  logic                 amt_zero_i,
  input  logic [W-1:0]         op_i,
  input  logic [W-1:0]         rot_i,
  input  logic                 cin_i,
  output logic                 cout_o
);
  import bsh_pkg::*;

  always_comb begin
    unique case (kind_i)
      SK_LSL:                 cout_o = amt_zero_i ? cin_i : rot_i[0];
      SK_LSR, SK_ASR, SK_ROR: cout_o = amt_zero_i ? cin_i : rot_i[W-1];
      SK_RCX:                 cout_o = op_i[0];
      default:                cout_o = cin_i;
    endcase
  end
endmodule

// File: rtl/barrel_shifter_cout.sv
module barrel_shifter_cout (
  input  logic [31:0] op_i,
  input  logic [2:0]  kind_i,
  input  logic [4:0]  amt_i,
  input  logic        cin_i,
  output logic [31:0] res_o,
  output logic        cout_o
);
  import bsh_pkg::*;

  localparam int unsigned W  = DATA_W;
  localparam int unsigned AW = AMT_W;

  shift_kind_e   kind;
  logic          is_left;
  logic          amt_zero;
  logic [AW-1:0] rot_amt;
  logic [W-1:0]  rotated;
  logic [W-1:0]  keep;
  logic          fill_bit;

  assign kind     = shift_kind_e'(kind_i);
  assign is_left  = (kind == SK_LSL);
  assign amt_zero = (amt_i == '0);
  // Left by n equals right rotation by (W - n) mod W.
  assign rot_amt  = is_left ? AW'(~amt_i + 1'b1) : amt_i;

  bsh_rotr #(.W(W)) u_rotr (
    .data_i (op_i),
    .amt_i  (rot_amt),
    .data_o (rotated)
  );

  bsh_fill_mask #(.W(W)) u_mask (
    .amt_i  (amt_i),
    .left_i (is_left),
    .keep_o (keep)
  );

  bsh_carry_sel #(.W(W)) u_csel (
    .kind_i     (kind),
    .amt_zero_i (amt_zero),
    .op_i       (op_i),
    .rot_i      (rotated),
    .cin_i      (cin_i),
    .cout_o     (cout_o)
  );

  assign fill_bit = (kind == SK_ASR) ? op_i[W-1] : 1'b0;

  always_comb begin
    unique case (kind)
      SK_LSL, SK_LSR, SK_ASR: res_o = (rotated & keep) | ({W{fill_bit}} & ~keep);
      SK_ROR:                 res_o = rotated;
      SK_RCX:                 res_o = {cin_i, op_i[W-1:1]};
      default:                res_o = op_i;
    endcase
  end

  // Checks beside the output mux.
  always_comb begin
    if (kind == SK_LSL && !amt_zero) begin
      assert_lsl_low_zero_R1: assert ((res_o << (W - int'(amt_i))) == '0)
        else $error("left shift left nonzero low bits");
    end
    if (kind == SK_LSR && !amt_zero) begin
      assert_lsr_high_zero_R2: assert ((res_o >> (W - int'(amt_i))) == '0)
        else $error("logical right shift left nonzero high bits");
    end
    if (kind == SK_ASR) begin
      assert_asr_sign_kept_R3: assert (res_o[W-1] == op_i[W-1])
        else $error("arithmetic shift changed the sign");
    end
    if (kind == SK_ROR) begin
      assert_ror_popcount_R4: assert ($countones(res_o) == $countones(op_i))
        else $error("rotation changed the number of set bits");
    end
    if (kind == SK_ROR && !amt_zero) begin
      assert_ror_carry_top_R6: assert (cout_o == res_o[W-1])
        else $error("rotate carry differs from result bit 31");
    end
    if (kind == SK_RCX) begin
      assert_rcx_ring_R5: assert (res_o[W-1] == cin_i && cout_o == op_i[0])
        else $error("carry rotation ring broken");
    end
    if (amt_zero && kind_i[2] == 1'b0) begin
      assert_zero_dist_pass_R7: assert (res_o == op_i && cout_o == cin_i)
        else $error("zero distance altered data or carry");
    end
    if (kind_i[2] && kind_i[1:0] != 2'b00) begin
      assert_unused_pass_R8: assert (res_o == op_i && cout_o == cin_i)
        else $error("unused code altered data or carry");
    end
  end
endmodule

// File: tb/barrel_shifter_cout_tb.sv
`timescale 1ns/1ps
module barrel_shifter_cout_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] op;
  logic [2:0]  kind;
  logic [4:0]  amt;
  logic        cin;
  logic [31:0] res;
  logic        cout;

  int n_vec  = 0;
  int n_fail = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  barrel_shifter_cout u_dut (
    .op_i   (op),
    .kind_i (kind),
    .amt_i  (amt),
    .cin_i  (cin),
    .res_o  (res),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [32:0] model(input logic [31:0] o, input logic [2:0] k,
                                        input int a, input logic c);
    logic [63:0] t;
    logic [31:0] r;
    logic        co;
    case (k)
      3'b000: begin t = {32'b0, o} << a; r = t[31:0];  co = (a == 0) ? c : t[32]; end
      3'b001: begin t = {o, 32'b0} >> a; r = t[63:32]; co = (a == 0) ? c : t[31]; end
      3'b010: begin t = $signed({o, 32'b0}) >>> a; r = t[63:32]; co = (a == 0) ? c : t[31]; end
      3'b011: begin t = {o, o} >> a; r = t[31:0]; co = (a == 0) ? c : r[31]; end
      3'b100: begin r = {c, o[31:1]}; co = o[0]; end
      default: begin r = o; co = c; end
    endcase
    return {co, r};
  endfunction

  function automatic logic [31:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic apply(input logic [31:0] o, input logic [2:0] k, input int a,
                       input logic c, input string tag);
    logic [32:0] exp;
    @(posedge clk);
    op = o; kind = k; amt = 5'(a); cin = c;
    exp = model(o, k, a, c);
    @(negedge clk);
    n_vec++;
    if (res !== exp[31:0] || cout !== exp[32]) begin
      n_fail++;
      $display("FAIL %s: op=%h kind=%b amt=%0d cin=%b got res=%h cout=%b expected res=%h cout=%b",
               tag, o, k, a, c, res, cout, exp[31:0], exp[32]);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    op = '0; kind = '0; amt = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (res !== 32'h0 || cout !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 idle: got res=%h cout=%b expected res=00000000 cout=0", res, cout);
    end
  endtask

  task automatic t_examples();
    apply(32'hFFFFFF00, 3'b000, 4, 1'b0, "R1 example");
    apply(32'hFFFFFF00, 3'b001, 4, 1'b0, "R2 example");
    apply(32'hFFFFFF00, 3'b010, 4, 1'b0, "R3 example");
    apply(32'h12345678, 3'b011, 4, 1'b0, "R4 example");
    apply(32'h80000001, 3'b100, 0, 1'b0, "R5 example");
  endtask

  task automatic t_sweep(input logic [2:0] k, input string tag);
    for (int a = 1; a < 32; a++) begin
      int pos;
      pos = (k == 3'b000) ? (32 - a) : (a - 1);
      apply(32'h1 << pos, k, a, 1'b0, tag);
      apply(~(32'h1 << pos), k, a, 1'b1, tag);
      apply(next_rand(), k, a, a[0], tag);
      apply(32'h8000_0000, k, a, 1'b0, tag);
    end
  endtask

  task automatic t_carry_extremes();
    apply(32'h0000_0002, 3'b000, 31, 1'b0, "R6 left31");
    apply(32'h4000_0000, 3'b001, 31, 1'b0, "R6 lsr31");
    apply(32'hBFFF_FFFF, 3'b010, 31, 1'b1, "R6 asr31");
    apply(32'h0000_0001, 3'b011, 1,  1'b0, "R6 ror1");
  endtask

  task automatic t_zero_dist();
    for (int k = 0; k < 4; k++) begin
      apply(32'hDEAD_BEEF, 3'(k), 0, 1'b1, "R7 zero");
      apply(32'h0123_4567, 3'(k), 0, 1'b0, "R7 zero");
    end
  endtask

  task automatic t_rcx();
    for (int a = 0; a < 32; a += 5) begin
      apply(32'h0000_0001, 3'b100, a, 1'b1, "R9 amt ignored");
      apply(32'hFFFF_FFFE, 3'b100, a, 1'b0, "R9 amt ignored");
    end
    apply(next_rand(), 3'b100, 17, 1'b1, "R5 random");
    apply(next_rand(), 3'b100, 3,  1'b0, "R5 random");
  endtask

  task automatic t_unused();
    for (int k = 5; k < 8; k++) begin
      apply(32'hCAFE_F00D, 3'(k), 7,  1'b1, "R8 unused");
      apply(32'h5555_AAAA, 3'(k), 31, 1'b0, "R8 unused");
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_examples();
    t_sweep(3'b000, "R1 R6 left");
    t_sweep(3'b001, "R2 R6 lsr");
    t_sweep(3'b010, "R3 R6 asr");
    t_sweep(3'b011, "R4 R6 ror");
    t_carry_extremes();
    t_zero_dist();
    t_rcx();
    t_unused();
    finish_run();
  end
endmodule